// File: doc/BRIEF.md
# Power Button Fail-Safe Timer

This block guards against a hung system by watching an active-low power button. When the button stays pressed for a programmed number of 32 kHz timebase edges, it raises a forced-power-off request. The surrounding power-state logic uses that request to drop both the main and the auxiliary working-power enables. After a forced off, the block also raises a hold-in-standby indication for as long as the button remains pressed. This keeps the system from waking while the user is still holding the button.

A single 32-bit configuration word sets the behaviour. It holds a lock bit, an enable bit, a reserved field and a delay field. Once the lock bit is written as one, the word cannot be changed until the standby reset (`rst_ni`) is applied. The button passes through a two-flop synchronizer. It is then sampled only on cycles where the timebase strobe `tick_i` is high, so a press shorter than one timebase edge may be missed.

Top module: `pwrbtn_failsafe`

## Requirements
- R1: While `rst_ni` is low and after it rises, `rd_data_o` reads 0, and `force_off_o` and `hold_stby_o` are 0.
- R2: The lock bit is bit 31, the enable bit is bit 30 and the delay field is bits DLY_W-1:0. Bits 29:DLY_W always read 0. Every other bit reads back the last accepted write one cycle after `wr_en_i`.
- R3: Once bit 31 reads 1, writes are ignored and `rd_data_o` stays unchanged until `rst_ni` is pulsed low. After that pulse it reads 0.
- R4: While bit 30 is 0, `force_off_o` never rises, however long the button is held.
- R5: The button is pressed when `btn_ni` is 0. It is seen through a two-cycle synchronizer and counted only on cycles with `tick_i` high. `force_off_o` rises at the clock edge of the tick that brings the count of consecutive pressed ticks to max(delay, 1).
- R6: A tick that samples the button released clears the count, so a new press must collect the full count again.
- R7: An accepted write while the button is held clears the count, including on a tick cycle. Counting resumes from zero on the following ticks.
- R8: Once raised, `force_off_o` stays 1 through any further ticks of the same press. It clears only at the edge of the first tick that samples the button released.
- R9: `hold_stby_o` is 1 exactly while `force_off_o` is 1 and the synchronized button is pressed. It falls two cycles after `btn_ni` returns high, without waiting for a tick.
- R10: A write that is ignored because the word is locked does not restart the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Standby reset, asynchronous, active low |
| wr_en_i | input | 1 | Configuration write strobe |
| wr_data_i | input | 32 | Configuration write data |
| rd_data_o | output | 32 | Configuration read data |
| btn_ni | input | 1 | Power button, active low, asynchronous |
| tick_i | input | 1 | One-cycle strobe per 32 kHz timebase edge |
| force_off_o | output | 1 | Request to drop both working-power enables |
| hold_stby_o | output | 1 | Keep the system in standby while the button is held |

## Verification
The bench builds the block with DLY_W = 4, so the delay field has only 16 values. The bench sweeps every one of them, including the zero case, against press lengths that run past the firing point. This confirms the max(delay, 1) firing tick and that the request does not fire a second time. The narrow field also places the reserved-bit boundary at bit 4, so a single all-ones write checks that the reserved bits read zero and that the lock takes effect. Directed sequences cover re-press restart, write restart, locked writes, a disabled timer, release timing of the hold indication and the standby reset.

// File: rtl/pbfs_pkg.sv
package pbfs_pkg;
  localparam int unsigned REG_W     = 32;
  localparam int unsigned LOCK_BIT  = 31;
  localparam int unsigned EN_BIT    = 30;
  localparam int unsigned DEF_DLY_W = 20;
  localparam int unsigned SYNC_STG  = 2;
endpackage

// File: rtl/pbfs_sync.sv
module pbfs_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] stg_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stg
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[g] <= RST_VAL;
        else if (g == 0) stg_q[g] <= d_i;
        else stg_q[g] <= stg_q[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/pbfs_cfg_reg.sv
module pbfs_cfg_reg
  import pbfs_pkg::*;
#(
  parameter int unsigned DLY_W = DEF_DLY_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wr_data_i,
  output logic [REG_W-1:0] rd_data_o,
  output logic             en_o,
  output logic [DLY_W-1:0] dly_o,
  output logic             restart_o
);
  localparam int unsigned RSV_W = EN_BIT - DLY_W;

  logic             lock_q;
  logic             en_q;
  logic [DLY_W-1:0] dly_q;
  logic             accept;

  // locked writes are dropped entirely
  assign accept = wr_en_i & ~lock_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lock_q <= 1'b0;
      en_q   <= 1'b0;
      dly_q  <= '0;
    end else if (accept) begin
      lock_q <= wr_data_i[LOCK_BIT];
      en_q   <= wr_data_i[EN_BIT];
      dly_q  <= wr_data_i[DLY_W-1:0];
    end
  end

  assign rd_data_o = {lock_q, en_q, {RSV_W{1'b0}}, dly_q};
  assign en_o      = en_q;
  assign dly_o     = dly_q;
  assign restart_o = accept;
endmodule

// File: rtl/pbfs_press_timer.sv
module pbfs_press_timer #(
  parameter int unsigned DLY_W = 20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             pressed_i,
  input  logic             en_i,
  input  logic [DLY_W-1:0] dly_i,
  input  logic             restart_i,
  output logic             force_off_o,
  output logic             hold_stby_o
);
  localparam int unsigned CMP_W = DLY_W + 1;

  logic [DLY_W-1:0] cnt_q;
  logic             off_q;
  logic [CMP_W-1:0] cnt_nxt;
  logic             hit;
  logic             fire;

  assign cnt_nxt = {1'b0, cnt_q} + CMP_W'(1);
  // zero delay behaves as one edge
  assign hit     = cnt_nxt >= {1'b0, dly_i};
  assign fire    = tick_i & pressed_i & en_i & ~off_q & hit & ~restart_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      off_q <= 1'b0;
    end else if (tick_i && !pressed_i) begin
      off_q <= 1'b0;
    end else if (fire) begin
      off_q <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (restart_i) begin
      cnt_q <= '0;
    end else if (tick_i) begin
      if (!pressed_i || !en_i) cnt_q <= '0;
      else if (!off_q && !hit) cnt_q <= cnt_nxt[DLY_W-1:0];
    end
  end

  assign force_off_o = off_q;
  assign hold_stby_o = off_q & pressed_i;
endmodule

// File: rtl/pwrbtn_failsafe.sv
module pwrbtn_failsafe
  import pbfs_pkg::*;
#(
  parameter int unsigned DLY_W = DEF_DLY_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wr_data_i,
  output logic [REG_W-1:0] rd_data_o,
  input  logic             btn_ni,
  input  logic             tick_i,
  output logic             force_off_o,
  output logic             hold_stby_o
);
  logic             btn_s;
  logic             en;
  logic [DLY_W-1:0] dly;
  logic             restart;

  pbfs_sync #(
    .STAGES (SYNC_STG),
    .RST_VAL(1'b1)
  ) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (btn_ni),
    .q_o   (btn_s)
  );

  pbfs_cfg_reg #(
    .DLY_W(DLY_W)
  ) u_cfg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .wr_data_i(wr_data_i),
    .rd_data_o(rd_data_o),
    .en_o     (en),
    .dly_o    (dly),
    .restart_o(restart)
  );

  pbfs_press_timer #(
    .DLY_W(DLY_W)
  ) u_tmr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick_i),
    .pressed_i  (~btn_s),
    .en_i       (en),
    .dly_i      (dly),
    .restart_i  (restart),
    .force_off_o(force_off_o),
    .hold_stby_o(hold_stby_o)
  );
endmodule

// File: rtl/pwrbtn_failsafe_chk.sv
module pwrbtn_failsafe_chk #(
  parameter int unsigned DLY_W = 20
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        tick_i,
  input logic [31:0] rd_data_o,
  input logic        force_off_o,
  input logic        hold_stby_o
);
  AST_RSVD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_o[29:DLY_W] == '0); // R2

  AST_LOCK_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rd_data_o[31]) |-> rd_data_o == $past(rd_data_o)); // R3

  AST_OFF_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(force_off_o) |-> ($past(rd_data_o[30]) && $past(tick_i))); // R4

  AST_OFF_CLEARS_ON_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(force_off_o) |-> $past(tick_i)); // R8

  AST_HOLD_NEEDS_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_stby_o |-> force_off_o); // R9
endmodule

bind pwrbtn_failsafe pwrbtn_failsafe_chk #(.DLY_W(DLY_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .tick_i     (tick_i),
  .rd_data_o  (rd_data_o),
  .force_off_o(force_off_o),
  .hold_stby_o(hold_stby_o)
);

// File: tb/pwrbtn_failsafe_tb.sv
module pwrbtn_failsafe_tb;
  localparam int unsigned DW = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        btn_n = 1'b1;
  logic        tick = 1'b0;
  logic        force_off;
  logic        hold_stby;

  int unsigned total = 0;
  int unsigned bad = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  pwrbtn_failsafe #(.DLY_W(DW)) u_dut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .wr_en_i    (wr_en),
    .wr_data_i  (wr_data),
    .rd_data_o  (rd_data),
    .btn_ni     (btn_n),
    .tick_i     (tick),
    .force_off_o(force_off),
    .hold_stby_o(hold_stby)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic pulse_tick();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
  endtask

  task automatic set_btn(input logic pressed);
    @(negedge clk); btn_n = ~pressed;
    repeat (3) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) pulse_tick();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 rd", rd_data, 32'h0);
    check("R1 off", {31'b0, force_off}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 rd after", rd_data, 32'h0);
    check("R1 hold", {31'b0, hold_stby}, 32'h0);

    // exhaustive delay sweep
    for (int d = 0; d < 16; d++) begin
      int fire_at;
      fire_at = (d == 0) ? 1 : d;
      wr(32'h4000_0000 | d);
      check("R2 readback", rd_data, 32'h4000_0000 | d);
      set_btn(1'b1);
      for (int i = 1; i <= 17; i++) begin
        pulse_tick();
        check("R5/R8 off", {31'b0, force_off}, {31'b0, (i >= fire_at)});
        check("R9 hold", {31'b0, hold_stby}, {31'b0, (i >= fire_at)});
      end
      set_btn(1'b0);
      check("R9 hold release", {31'b0, hold_stby}, 32'h0);
      check("R8 off until tick", {31'b0, force_off}, 32'h1);
      pulse_tick();
      check("R8 off cleared", {31'b0, force_off}, 32'h0);
    end

    // R6: release restarts count
    wr(32'h4000_0005);
    set_btn(1'b1); ticks(3);
    set_btn(1'b0); pulse_tick();
    set_btn(1'b1); ticks(4);
    check("R6 no fire early", {31'b0, force_off}, 32'h0);
    pulse_tick();
    check("R6 fire", {31'b0, force_off}, 32'h1);
    set_btn(1'b0); pulse_tick();

    // R7: write restarts count
    set_btn(1'b1); ticks(3);
    wr(32'h4000_0005);
    ticks(4);
    check("R7 no fire early", {31'b0, force_off}, 32'h0);
    pulse_tick();
    check("R7 fire", {31'b0, force_off}, 32'h1);
    set_btn(1'b0); pulse_tick();

    // R7: write on a tick cycle wins
    set_btn(1'b1); ticks(4);
    @(negedge clk); tick = 1'b1; wr_en = 1'b1; wr_data = 32'h4000_0005;
    @(negedge clk); tick = 1'b0; wr_en = 1'b0;
    check("R7 tick+write no fire", {31'b0, force_off}, 32'h0);
    ticks(4);
    check("R7 tick+write still counting", {31'b0, force_off}, 32'h0);
    pulse_tick();
    check("R7 tick+write fire", {31'b0, force_off}, 32'h1);
    set_btn(1'b0); pulse_tick();

    // R4: disabled
    wr(32'h0000_0002);
    set_btn(1'b1); ticks(20);
    check("R4 disabled", {31'b0, force_off}, 32'h0);
    set_btn(1'b0); pulse_tick();

    // R3/R10: locked
    wr(32'hC000_0005);
    check("R3 lock readback", rd_data, 32'hC000_0005);
    set_btn(1'b1); ticks(3);
    wr(32'h4000_0002);
    check("R3 locked write ignored", rd_data, 32'hC000_0005);
    ticks(1);
    check("R10 no restart early", {31'b0, force_off}, 32'h0);
    ticks(1);
    check("R10 fire on original count", {31'b0, force_off}, 32'h1);
    set_btn(1'b0); pulse_tick();
    do_reset();
    check("R3 reset unlocks", rd_data, 32'h0);

    // R2: reserved bits
    wr(32'hFFFF_FFFF);
    check("R2 reserved zero", rd_data, 32'hC000_000F);
    wr(32'h0);
    check("R3 locked after all-ones", rd_data, 32'hC000_000F);
    do_reset();
    check("R1 after reset", rd_data, 32'h0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: act=running exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule